// File: doc/BRIEF.md
# Biphase-Mark Stereo Audio Line Transmitter

This block turns a stream of stereo 24-bit PCM sample pairs into a consumer-format serial digital audio line. Each sample period becomes one frame made of two 32-bit sub-frames, left channel first and then right. Every sub-frame opens with an 8-state sync preamble. After it come the sample, the validity flag, a user bit, one channel-status bit and an even-parity bit. All data bits are sent with biphase-mark coding at 128 line states per sample period.

Frames are grouped into 192-frame blocks. The first sub-frame of each block carries a distinct preamble, and the channel-status word is sent one bit per frame across the block. The sample source writes a new pair into a holding register at any time before a frame starts. A frame whose start finds no new pair sends the previous pair again. The channel-status word, validity flag, stereo flag and output enable are static inputs. The line rate comes from a parameterised divider: one line state lasts `STATE_DIV` clocks.

Top module: `bmc_audio_tx`

## Requirements
- R1: While `rst` is high or `tx_en` is low, `tx_line` is 0 from the next clock edge onward. While `tx_en` is low, the sequencer waits at the first state of frame 0.
- R2: Each sub-frame starts with 8 preamble states, sent left to right. With a preceding line level of 0 the patterns are: 11101000 for the first sub-frame of frame 0, 11100010 for the first sub-frame of every other frame, and 11100100 for every second sub-frame.
- R3: With a preceding line level of 1, each preamble pattern is the bitwise inverse of its pattern for level 0. The first preamble state therefore always differs from the state before it.
- R4: Sub-frame bits 4 to 27 carry the two's-complement sample, LSB in bit 4 and MSB in bit 27. The left sample goes in the first sub-frame and the right sample in the second.
- R5: Bit 28 equals `valid_flag`, where 1 marks the sample as unreliable. Bit 29 (user data) is always 0. Bit 31 makes bits 4 to 31 together hold an even number of ones.
- R6: Each of bits 4 to 31 takes two line states. The first state is the inverse of the state before it. The second state is inverted again when the bit is 1 and repeats the first when the bit is 0. Every line state lasts `STATE_DIV` clocks.
- R7: Bit 30 of both sub-frames of frame n (0 to 191) carries `cs_word[n]` for n below 42, and 0 for n of 42 or more, except as given in R8.
- R8: For frames 20 to 23, bit 30 comes from the stereo rule and not from `cs_word`. With `stereo`=1, bits 20..23 read 1,0,0,0 in the first sub-frame and 0,1,0,0 in the second. With `stereo`=0 they are all 0.
- R9: At the start of each frame, the pair most recently written with `smp_valid` becomes the frame's sample. If no pair was written since the previous frame started, the previous pair is sent again.
- R10: Frame numbers run from 0 to 191 and then wrap. The frame after frame 191 opens with the block-start preamble again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Output enable; low holds the line low and parks the sequencer |
| smp_valid | input | 1 | Writes `smp_left`/`smp_right` into the holding register |
| smp_left | input | 24 | Left (channel 1) sample, two's complement |
| smp_right | input | 24 | Right (channel 2) sample, two's complement |
| cs_word | input | 42 | Channel-status bits 0..41; bit n goes in frame n |
| valid_flag | input | 1 | Sent as the validity bit; 1 means unreliable |
| stereo | input | 1 | Selects the stereo channel-number code in status bits 20..23 |
| tx_line | output | 1 | Biphase-mark coded serial line |

## Verification
The bench decodes the line state by state over a complete block and the first frame of the next. Watching the wrap from frame 191 back to 0 catches an off-by-one block counter: such a design would send the block-start preamble one frame early or late, or never. Channel-status frames 20 to 23 are checked under both settings of the stereo flag with a dense `cs_word`. A design that leaks `cs_word` into those frames, or swaps the left and right codes, gets a wrong bit 30 there. Some frames are given no new sample pair, and the enable is dropped and raised again mid-stream. These cases expose a design that sends stale or zero samples, latches the pair too late, or does not restart the block cleanly with the line starting low.

// File: rtl/bmt_pkg.sv
package bmt_pkg;
  localparam int SUB_BITS   = 32;
  localparam int SUB_STATES = 2 * SUB_BITS;
  localparam int SLOT_W     = $clog2(SUB_STATES);
  localparam int PRE_STATES = 8;

  typedef enum logic [1:0] {
    PRE_BLK = 2'd0,
    PRE_CH1 = 2'd1,
    PRE_CH2 = 2'd2
  } pre_t;

  // state pattern for a preceding line level of 0, first state in bit 7
  function automatic logic [PRE_STATES-1:0] pre_pattern(input pre_t p);
    case (p)
      PRE_BLK: pre_pattern = 8'b1110_1000;
      PRE_CH1: pre_pattern = 8'b1110_0010;
      default: pre_pattern = 8'b1110_0100;
    endcase
  endfunction
endpackage

// File: rtl/bmt_timebase.sv
module bmt_timebase
  import bmt_pkg::*;
#(
  parameter int STATE_DIV = 2,
  parameter int FRAMES    = 192,
  localparam int FW = $clog2(FRAMES),
  localparam int DW = (STATE_DIV > 1) ? $clog2(STATE_DIV) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  output logic              tick,
  output logic [SLOT_W-1:0] slot,
  output logic              sub,
  output logic [FW-1:0]     frame
);
  localparam logic [SLOT_W-1:0] LAST_SLOT  = SLOT_W'(SUB_STATES - 1);
  localparam logic [FW-1:0]     LAST_FRAME = FW'(FRAMES - 1);

  generate
    if (STATE_DIV > 1) begin : g_div
      logic [DW-1:0] div_q;
      always_ff @(posedge clk) begin
        if (rst || !run)                      div_q <= '0;
        else if (div_q == DW'(STATE_DIV - 1)) div_q <= '0;
        else                                  div_q <= div_q + 1'b1;
      end
      assign tick = run && (div_q == DW'(STATE_DIV - 1));
    end else begin : g_nodiv
      assign tick = run;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      slot  <= '0;
      sub   <= 1'b0;
      frame <= '0;
    end else if (tick) begin
      if (slot == LAST_SLOT) begin
        slot <= '0;
        sub  <= ~sub;
        if (sub) frame <= (frame == LAST_FRAME) ? '0 : frame + 1'b1;
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end

  // R10: the frame counter never leaves the block range
  a_r10_frame_bound: assert property (@(posedge clk) disable iff (rst)
    frame <= LAST_FRAME);
endmodule

// File: rtl/bmt_subframe.sv
module bmt_subframe
  import bmt_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int CS_BITS  = 42,
  parameter int FRAMES   = 192,
  localparam int FW  = $clog2(FRAMES),
  localparam int CSW = $clog2(CS_BITS)
) (
  input  logic [SAMPLE_W-1:0] sample,
  input  logic                sub,
  input  logic [FW-1:0]       frame,
  input  logic [CS_BITS-1:0]  cs_word,
  input  logic                valid_flag,
  input  logic                stereo,
  output pre_t                pre,
  output logic [SUB_BITS-1:0] word
);
  localparam int AUD_LO = 4;
  localparam int V_POS  = 28;
  localparam int U_POS  = 29;
  localparam int C_POS  = 30;
  localparam int P_POS  = 31;
  localparam int CH_LO  = 20;
  localparam int CH_HI  = 23;

  logic cs_bit;

  always_comb begin
    cs_bit = 1'b0;
    if (frame < FW'(CS_BITS)) cs_bit = cs_word[frame[CSW-1:0]];
    if (frame >= FW'(CH_LO) && frame <= FW'(CH_HI))
      cs_bit = stereo && (frame == (sub ? FW'(CH_LO + 1) : FW'(CH_LO)));
  end

  always_comb begin
    word = '0;
    word[AUD_LO + SAMPLE_W - 1 : AUD_LO] = sample;
    word[V_POS] = valid_flag;
    word[U_POS] = 1'b0;
    word[C_POS] = cs_bit;
    word[P_POS] = ^word[C_POS:AUD_LO];
  end

  always_comb begin
    if (sub)                  pre = PRE_CH2;
    else if (frame == '0)     pre = PRE_BLK;
    else                      pre = PRE_CH1;
  end
endmodule

// File: rtl/bmt_encoder.sv
module bmt_encoder
  import bmt_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                tick,
  input  logic [SLOT_W-1:0]   slot,
  input  pre_t                pre,
  input  logic [SUB_BITS-1:0] word,
  output logic                line
);
  logic                  line_q, pol_q, lvl_n;
  logic [PRE_STATES-1:0] pat;
  logic [SLOT_W-2:0]     bit_i;

  always_comb begin
    pat   = pre_pattern(pre);
    bit_i = slot[SLOT_W-1:1];
    if (slot < SLOT_W'(PRE_STATES)) begin
      if (slot == '0) lvl_n = pat[PRE_STATES-1] ^ line_q;
      else            lvl_n = pat[3'd7 - slot[2:0]] ^ pol_q;
    end else if (!slot[0]) begin
      lvl_n = ~line_q;
    end else begin
      lvl_n = line_q ^ word[bit_i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      line_q <= 1'b0;
      pol_q  <= 1'b0;
    end else if (tick) begin
      line_q <= lvl_n;
      if (slot == '0) pol_q <= line_q;
    end
  end

  assign line = line_q;

  // R1: disabled output goes low at the next edge
  a_r1_line_low: assert property (@(posedge clk) disable iff (rst)
    !en |=> !line_q);
  // R3: the preamble opens with a change of level
  a_r3_pre_edge: assert property (@(posedge clk) disable iff (rst)
    (en && tick && slot == '0) |=> (line_q != $past(line_q)));
  // R6: every data bit opens with a change of level
  a_r6_bit_edge: assert property (@(posedge clk) disable iff (rst)
    (en && tick && slot >= SLOT_W'(PRE_STATES) && !slot[0]) |=> (line_q != $past(line_q)));
  // R6: the line only moves on a state tick
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> $stable(line_q));
endmodule

// File: rtl/bmc_audio_tx.sv
module bmc_audio_tx
  import bmt_pkg::*;
#(
  parameter int STATE_DIV = 2,
  parameter int SAMPLE_W  = 24,
  parameter int CS_BITS   = 42,
  parameter int FRAMES    = 192,
  localparam int FW = $clog2(FRAMES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tx_en,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic [CS_BITS-1:0]  cs_word,
  input  logic                valid_flag,
  input  logic                stereo,
  output logic                tx_line
);
  logic                tick, sub;
  logic [SLOT_W-1:0]   slot;
  logic [FW-1:0]       frame;
  logic [SAMPLE_W-1:0] hold_l, hold_r, cur_l, cur_r;
  logic                frame_start;
  pre_t                pre;
  logic [SUB_BITS-1:0] word;

  assign frame_start = tick && (slot == '0) && !sub;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_l <= '0;
      hold_r <= '0;
      cur_l  <= '0;
      cur_r  <= '0;
    end else begin
      if (smp_valid) begin
        hold_l <= smp_left;
        hold_r <= smp_right;
      end
      if (frame_start) begin
        cur_l <= hold_l;
        cur_r <= hold_r;
      end
    end
  end

  bmt_timebase #(.STATE_DIV(STATE_DIV), .FRAMES(FRAMES)) tb_i (
    .clk(clk), .rst(rst), .run(tx_en),
    .tick(tick), .slot(slot), .sub(sub), .frame(frame)
  );

  bmt_subframe #(.SAMPLE_W(SAMPLE_W), .CS_BITS(CS_BITS), .FRAMES(FRAMES)) sf_i (
    .sample(sub ? cur_r : cur_l), .sub(sub), .frame(frame),
    .cs_word(cs_word), .valid_flag(valid_flag), .stereo(stereo),
    .pre(pre), .word(word)
  );

  bmt_encoder enc_i (
    .clk(clk), .rst(rst), .en(tx_en), .tick(tick),
    .slot(slot), .pre(pre), .word(word), .line(tx_line)
  );

  // R9: a frame start loads the held pair
  a_r9_latch: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (cur_l == $past(hold_l) && cur_r == $past(hold_r)));
endmodule

// File: tb/bmc_audio_tx_tb_top.sv
module bmc_audio_tx_tb_top;
  localparam int DIV = 2;

  logic clk = 1'b0, rst = 1'b1, tx_en = 1'b0, smp_valid = 1'b0;
  logic valid_flag = 1'b0, stereo = 1'b0;
  logic [23:0] smp_left = '0, smp_right = '0;
  logic [41:0] cs_word = '0;
  logic tx_line;

  int total = 0, bad = 0, seq = 0;
  bit done = 0;
  logic [23:0] pend_l = '0, pend_r = '0;
  bit pend_fresh = 0;

  always #2 clk = ~clk;

  bmc_audio_tx #(.STATE_DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .tx_en(tx_en), .smp_valid(smp_valid),
    .smp_left(smp_left), .smp_right(smp_right), .cs_word(cs_word),
    .valid_flag(valid_flag), .stereo(stereo), .tx_line(tx_line)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic offer();
    seq++;
    smp_left   = 24'(seq * 24'h3B9A7 + 24'h5A1);
    smp_right  = smp_left ^ 24'hFFF0F0;
    smp_valid  = 1'b1;
    pend_l     = smp_left;
    pend_r     = smp_right;
    pend_fresh = 1;
  endtask

  task automatic get_state(output logic v);
    repeat (DIV) @(posedge clk);
    @(negedge clk);
    smp_valid = 1'b0;
    v = tx_line;
  endtask

  task automatic run_frames(input int n);
    logic s [64];
    logic prv, lvl, expcs;
    logic [7:0] pat, got8;
    logic [31:0] w;
    logic [23:0] cur_l, cur_r;
    bit rep;
    int fi;
    prv = 1'b0;
    for (int f = 0; f < n; f++) begin
      cur_l = pend_l; cur_r = pend_r; rep = !pend_fresh; pend_fresh = 0;
      fi = f % 192;
      for (int sb = 0; sb < 2; sb++) begin
        for (int k = 0; k < 64; k++) begin
          get_state(s[k]);
          if (sb == 0 && k == 20 && (f % 7) != 3) offer();
        end
        pat = (sb == 1) ? 8'b11100100 : (fi == 0) ? 8'b11101000 : 8'b11100010;
        if (prv) pat = ~pat;
        for (int k = 0; k < 8; k++) got8[7-k] = s[k];
        chk(got8 == pat, (f == 192) ? "R10" : "R2", "preamble", got8, pat);
        chk(s[0] != prv, "R3", "preamble first state", s[0], ~prv);
        lvl = s[7];
        w = '0;
        for (int b = 4; b < 32; b++) begin
          chk(s[2*b] != lvl, "R6", "bit start transition", s[2*b], ~lvl);
          w[b] = s[2*b] != s[2*b+1];
          lvl = s[2*b+1];
        end
        chk(w[27:4] == (sb ? cur_r : cur_l), rep ? "R9" : "R4", "sample",
            w[27:4], sb ? cur_r : cur_l);
        chk(w[28] == valid_flag, "R5", "validity bit", w[28], valid_flag);
        chk(w[29] == 1'b0, "R5", "user bit", w[29], 0);
        chk((^w[31:4]) == 1'b0, "R5", "parity", w[31:4], 0);
        if (fi >= 20 && fi <= 23) expcs = stereo && (fi == (sb ? 21 : 20));
        else if (fi < 42)         expcs = cs_word[fi];
        else                      expcs = 1'b0;
        chk(w[30] == expcs, (fi >= 20 && fi <= 23) ? "R8" : "R7", "status bit", w[30], expcs);
        prv = s[63];
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(tx_line == 1'b0, "R1", "line in reset", tx_line, 0);
    rst = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(tx_line == 1'b0, "R1", "line while disabled", tx_line, 0);
    end
    // run one: stereo, valid samples, full block plus one frame
    cs_word = 42'h2B5_C3F0_96E1;
    stereo = 1'b1; valid_flag = 1'b0;
    offer();
    @(negedge clk); smp_valid = 1'b0;
    tx_en = 1'b1;
    run_frames(193);
    tx_en = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(tx_line == 1'b0, "R1", "line after disable", tx_line, 0);
    end
    // run two: mono code, unreliable flag, new status word, restart of block
    cs_word = 42'h3FF_FFFF_FFFF;
    stereo = 1'b0; valid_flag = 1'b1;
    offer();
    @(negedge clk); smp_valid = 1'b0;
    tx_en = 1'b1;
    run_frames(25);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule